// File: doc/BRIEF.md
# Slot Identity Address Comparator

This block decides whether a transfer on a 16-bit multiplexed address/data bus is aimed at the local card. It looks only at the upper byte of the bus value and compares it with the card's 4-bit slot identifier. Two address spaces are decoded from that one identifier. The standard slot space needs a zero top nibble followed by the slot ID. The super-slot space needs a top nibble equal to the slot ID.

Both decisions are captured on the rising edge of the address clock and held until the next one. The two active-low flags go to the local bus controller, which uses them to accept or ignore the transfer. The slot ID is static board configuration; the block reads it only at address clock edges. At the pads, undriven ID pins are pulled high and read as all ones.

Top module: `slot_id_match`

## Requirements
- R1: Both match flags are active low: a registered 0 means the transfer matches, a 1 means it does not.
- R2: After a rising address clock edge, `std_hit_n` is 0 exactly when bus bits 15..12 were 0000 at that edge and bus bits 11..8 equalled `slot_id` at that edge.
- R3: After a rising address clock edge, `super_hit_n` is 0 exactly when bus bits 15..12 equalled a nonzero `slot_id` at that edge.
- R4: When `slot_id` is 0000 at an edge, `super_hit_n` is 1 after that edge, whatever the bus value.
- R5: Both flags keep their values between rising address clock edges, even when the bus value changes.
- R6: With `rst` high at a rising edge, both flags are 1 after that edge.
- R7: The two flags are never 0 at the same time.
- R8: A change of `slot_id` between rising edges has no effect on either flag until the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| addr_clk | input | 1 | Address clock; flags update on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| ad_bus | input | 16 | Multiplexed address/data bus value |
| slot_id | input | 4 | Card slot identifier (static configuration) |
| std_hit_n | output | 1 | Standard slot space match, active low |
| super_hit_n | output | 1 | Super-slot space match, active low |

## Verification
On every clock the assertions relate each flag to the bus and ID values sampled one edge earlier, and they check that the zero-ID suppression, reset response and mutual exclusion of the two flags hold. What the flags do between edges is invisible to those edge-sampled properties, so only the bench can show that disturbing the bus or the slot ID mid-cycle leaves both flags untouched. The bench also sweeps all sixteen IDs against every upper-byte pattern, which covers each match and near-miss combination once.

// File: rtl/slot_cmp_pkg.sv
package slot_cmp_pkg;

    // Which address space a decoder instance recognises.
    typedef enum logic [0:0] {
        SPACE_STD   = 1'b0,
        SPACE_SUPER = 1'b1
    } space_e;

    localparam int unsigned SPACE_COUNT = 2;

    // Active-high decode result carried between the decoders and the register.
    typedef struct packed {
        logic super_hit;
        logic std_hit;
    } slot_hit_t;

    // Convert an active-high hit into the flag level on the pins.
    function automatic logic to_flag_n(input logic hit);
        return ~hit;
    endfunction

endpackage

// File: rtl/slot_field_split.sv
module slot_field_split #(
    parameter int unsigned ID_W = 4
) (
    input  logic [2*ID_W-1:0] upper_bits,
    output logic [ID_W-1:0]   top_field,
    output logic [ID_W-1:0]   next_field
);
    // Upper field sits in the most significant nibble, the second just below.
    assign top_field  = upper_bits[2*ID_W-1 -: ID_W];
    assign next_field = upper_bits[ID_W-1:0];
endmodule

// File: rtl/slot_space_decoder.sv
module slot_space_decoder #(
    parameter int unsigned          ID_W  = 4,
    parameter slot_cmp_pkg::space_e SPACE = slot_cmp_pkg::SPACE_STD
) (
    input  logic [ID_W-1:0] top_field,
    input  logic [ID_W-1:0] next_field,
    input  logic [ID_W-1:0] slot_id,
    output logic            hit
);
    localparam logic [ID_W-1:0] ZERO_ID = '0;

    generate
        if (SPACE == slot_cmp_pkg::SPACE_STD) begin : g_std
            logic top_is_zero;
            logic next_is_id;
            logic unused_std;
            assign top_is_zero = (top_field == ZERO_ID);
            assign next_is_id  = (next_field == slot_id);
            assign hit         = top_is_zero & next_is_id;
            assign unused_std  = 1'b0;
        end else begin : g_super
            logic id_nonzero;
            logic top_is_id;
            logic unused_super;
            assign id_nonzero   = (slot_id != ZERO_ID);
            assign top_is_id    = (top_field == slot_id);
            assign hit          = id_nonzero & top_is_id;
            assign unused_super = ^next_field;
        end
    endgenerate
endmodule

// File: rtl/slot_hit_reg.sv
module slot_hit_reg (
    input  logic                    clk,
    input  logic                    rst,
    input  slot_cmp_pkg::slot_hit_t hit_d,
    output logic                    std_hit_n,
    output logic                    super_hit_n
);
    import slot_cmp_pkg::*;

    slot_hit_t hit_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            hit_q <= '0;
        end else begin
            hit_q <= hit_d;
        end
    end

    assign std_hit_n   = to_flag_n(hit_q.std_hit);
    assign super_hit_n = to_flag_n(hit_q.super_hit);
endmodule

// File: rtl/slot_id_match.sv
module slot_id_match #(
    parameter int unsigned BUS_W = 16,
    parameter int unsigned ID_W  = 4
) (
    input  logic             addr_clk,
    input  logic             rst,
    input  logic [BUS_W-1:0] ad_bus,
    input  logic [ID_W-1:0]  slot_id,
    output logic             std_hit_n,
    output logic             super_hit_n
);
    import slot_cmp_pkg::*;

    localparam int unsigned UPPER_W = 2 * ID_W;
    localparam int unsigned LOW_W   = BUS_W - UPPER_W;

    logic [ID_W-1:0] top_field;
    logic [ID_W-1:0] next_field;
    logic [SPACE_COUNT-1:0] space_hit;
    slot_hit_t hit_d;
    logic unused_low;

    assign unused_low = ^ad_bus[LOW_W-1:0];

    slot_field_split #(.ID_W(ID_W)) u_split (
        .upper_bits (ad_bus[BUS_W-1 -: UPPER_W]),
        .top_field  (top_field),
        .next_field (next_field)
    );

    generate
        for (genvar s = 0; s < SPACE_COUNT; s++) begin : g_space
            slot_space_decoder #(
                .ID_W  (ID_W),
                .SPACE (space_e'(s))
            ) u_dec (
                .top_field  (top_field),
                .next_field (next_field),
                .slot_id    (slot_id),
                .hit        (space_hit[s])
            );
        end
    endgenerate

    assign hit_d.std_hit   = space_hit[SPACE_STD];
    assign hit_d.super_hit = space_hit[SPACE_SUPER];

    slot_hit_reg u_reg (
        .clk         (addr_clk),
        .rst         (rst),
        .hit_d       (hit_d),
        .std_hit_n   (std_hit_n),
        .super_hit_n (super_hit_n)
    );
endmodule

// File: rtl/slot_id_match_chk.sv
module slot_id_match_chk #(
    parameter int unsigned BUS_W = 16,
    parameter int unsigned ID_W  = 4
) (
    input logic             addr_clk,
    input logic             rst,
    input logic [BUS_W-1:0] ad_bus,
    input logic [ID_W-1:0]  slot_id,
    input logic             std_hit_n,
    input logic             super_hit_n
);
    localparam logic [ID_W-1:0] ZID = '0;

    // R2 / R1: standard flag follows the previous edge's bus and ID.
    p_std_decode_r2: assert property (@(posedge addr_clk) disable iff (rst)
        1'b1 |=> (std_hit_n == !(($past(ad_bus[BUS_W-1 -: ID_W]) == ZID) &&
                                 ($past(ad_bus[BUS_W-1-ID_W -: ID_W]) == $past(slot_id)))));

    // R3: super flag follows the previous edge's bus and ID.
    p_super_decode_r3: assert property (@(posedge addr_clk) disable iff (rst)
        1'b1 |=> (super_hit_n == !(($past(slot_id) != ZID) &&
                                   ($past(ad_bus[BUS_W-1 -: ID_W]) == $past(slot_id)))));

    // R4: zero ID never yields a super-slot match.
    p_zero_id_r4: assert property (@(posedge addr_clk) disable iff (rst)
        (slot_id == ZID) |=> super_hit_n);

    // R6: reset releases both flags.
    p_reset_idle_r6: assert property (@(posedge addr_clk)
        rst |=> (std_hit_n && super_hit_n));

    // R7: the two spaces never match together.
    p_exclusive_r7: assert property (@(posedge addr_clk) disable iff (rst)
        !(!std_hit_n && !super_hit_n));
endmodule

bind slot_id_match slot_id_match_chk #(.BUS_W(BUS_W), .ID_W(ID_W)) u_chk (
    .addr_clk    (addr_clk),
    .rst         (rst),
    .ad_bus      (ad_bus),
    .slot_id     (slot_id),
    .std_hit_n   (std_hit_n),
    .super_hit_n (super_hit_n)
);

// File: tb/test_slot_id_match.sv
`timescale 1ns/100ps
module test_slot_id_match;
    logic        addr_clk = 1'b0;
    logic        rst      = 1'b1;
    logic [15:0] ad_bus   = 16'h0000;
    logic [3:0]  slot_id  = 4'h0;
    logic        std_hit_n;
    logic        super_hit_n;

    int checks   = 0;
    int failures = 0;
    bit done     = 1'b0;

    always #2 addr_clk = ~addr_clk;

    slot_id_match i_slot_id_match (
        .addr_clk    (addr_clk),
        .rst         (rst),
        .ad_bus      (ad_bus),
        .slot_id     (slot_id),
        .std_hit_n   (std_hit_n),
        .super_hit_n (super_hit_n)
    );

    task automatic check(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%b expected=%b bus=%h id=%h t=%0t",
                     req, act, exp, ad_bus, slot_id, $time);
        end
    endtask

    task automatic edge_drive(input logic r, input logic [15:0] b, input logic [3:0] id);
        @(negedge addr_clk);
        rst = r; ad_bus = b; slot_id = id;
        @(posedge addr_clk);
        #1;
    endtask

    initial begin
        #800000;
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        // R6 / R1: reset state, with a bus value that would otherwise match.
        edge_drive(1'b1, 16'h0F00, 4'hF);
        check("R6 std after reset", std_hit_n, 1'b1);
        check("R6 super after reset", super_hit_n, 1'b1);

        // Exhaustive sweep: every ID against every upper byte.
        for (int id = 0; id < 16; id++) begin
            for (int ub = 0; ub < 256; ub++) begin
                logic [3:0] top;
                logic [3:0] nxt;
                logic es;
                logic eu;
                top = 4'(ub >> 4);
                nxt = 4'(ub & 15);
                es  = !((top == 4'h0) && (nxt == 4'(id)));
                eu  = !((id != 0) && (top == 4'(id)));
                edge_drive(1'b0, {8'(ub), 8'((id * 37 + ub) & 255)}, 4'(id));
                check("R1/R2 standard decode", std_hit_n, es);
                check("R3 super decode", super_hit_n, eu);
                if (id == 0) check("R4 zero id no super", super_hit_n, 1'b1);
                check("R7 exclusive", !std_hit_n && !super_hit_n, 1'b0);
                // Disturb bus mid-cycle: flags must hold.
                ad_bus = ~ad_bus;
                #0.5;
                check("R5 std holds on bus change", std_hit_n, es);
                check("R5 super holds on bus change", super_hit_n, eu);
                // Disturb ID mid-cycle: flags must hold.
                slot_id = ~slot_id;
                #0.5;
                check("R8 std holds on id change", std_hit_n, es);
                check("R8 super holds on id change", super_hit_n, eu);
            end
        end

        // R6: reset clears an active standard match.
        edge_drive(1'b0, 16'h0300, 4'h3);
        check("R2 std match before reset", std_hit_n, 1'b0);
        edge_drive(1'b1, 16'h0300, 4'h3);
        check("R6 std cleared by reset", std_hit_n, 1'b1);

        // R6: reset clears an active super match.
        edge_drive(1'b0, 16'h5A00, 4'h5);
        check("R3 super match before reset", super_hit_n, 1'b0);
        edge_drive(1'b1, 16'h5A00, 4'h5);
        check("R6 super cleared by reset", super_hit_n, 1'b1);

        // R4: ID 0 with all-zero bus gives standard match only.
        edge_drive(1'b0, 16'h0000, 4'h0);
        check("R4 zero id super idle", super_hit_n, 1'b1);
        check("R2 zero id std match", std_hit_n, 1'b0);

        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule